// File: doc/BRIEF.md
# Accumulator ALU with Compare Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. One operand always comes from the accumulator. The other comes from the shared register bus. Eleven operations are computed side by side at all times: add, subtract, shift left, logical and arithmetic shift right, rotate left and right, AND, OR, XOR and NOT. A 4-bit operation code drives a multiplexer that chooses which of these reaches the result port. The result path is purely combinational. The enclosing datapath decides whether to write the result back into the accumulator.

Three flag registers hold zero, carry and negative. They change on a clock edge only while the compare strobe is high. At such an edge they take their values from the difference accumulator minus operand, and that difference is otherwise discarded. Add and subtract share one adder. For subtraction the adder is fed the inverted operand and a carry-in of 1. Compare drives the adder in the same subtract form. The block has no stream data interface: operands are sampled on every cycle with no valid/ready handshake, so no back-pressure can arise. All pins are plain control or data levels.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 (add) gives result = (acc + operand) mod 256.
- R2: Opcode 1 (subtract) gives result = (acc - operand) mod 256.
- R3: Opcode 2 (shift left) gives result = acc shifted up one bit, with bit 0 set to 0.
- R4: Opcode 3 (logical shift right) puts 0 into bit 7. Opcode 4 (arithmetic shift right) copies the old bit 7 into bit 7.
- R5: Opcode 5 (rotate left) moves old bit 7 into bit 0. Opcode 6 (rotate right) moves old bit 0 into bit 7.
- R6: Opcodes 7, 8 and 10 give the bitwise AND, OR and XOR of acc and operand. Opcode 9 gives the bitwise NOT of acc; the operand has no effect on it.
- R7: Opcodes 11 to 15 give a result of 0.
- R8: At a rising clock edge with the compare strobe high, the flags take values from d = acc - operand (mod 256). zero_o = 1 when d is 0. neg_o = bit 7 of d. carry_o = 1 when acc >= operand as unsigned numbers.
- R9: At a rising clock edge with the compare strobe low, the flags keep their values, whatever the opcode and operands are, including an add that carries out.
- R10: At a rising clock edge with reset high, all three flags clear to 0. Reset takes priority over a compare.
- R11: While the compare strobe is high, the shared adder subtracts. Opcode 0 and opcode 1 then both show acc - operand on the result port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op_i | input | 4 | Operation code that selects the result |
| cmp_i | input | 1 | Compare strobe; the flags load while it is high |
| acc_i | input | 8 | Accumulator operand |
| bus_i | input | 8 | Second operand from the register bus |
| result_o | output | 8 | Result chosen by the operation code |
| zero_o | output | 1 | Zero flag register |
| carry_o | output | 1 | Carry (no-borrow) flag register |
| neg_o | output | 1 | Negative flag register |

## Verification
The bench checks compares of equal operands, 0 against 1, and 0x80 against 0x7F. A wrong carry-in, or inversion on the wrong operand, would set the zero flag or the no-borrow carry incorrectly in these cases. It runs adds that overflow while the strobe is low, which would show up a design that updates the flags on every operation. It also checks the arithmetic shift of values with bit 7 set, where a logical shift would lose the sign, and rotates, where the wrapped bit could be dropped or land at the wrong end. Reset arrives together with a compare to check that reset wins. Random opcodes, including the unused codes, are driven with and without the strobe, which covers the case where compare forces the shared adder into subtraction.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_SHL = 4'd2,
    OP_SHR = 4'd3,
    OP_ASR = 4'd4,
    OP_ROL = 4'd5,
    OP_ROR = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_NOT = 4'd9,
    OP_XOR = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  end

  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];

  // R2
  always_comb begin
    if (sub_i && !$isunknown({a_i, b_i, sum_o}))
      sub_inverse_chk: assert (W'(sum_o + b_i) == a_i);
  end
endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] shl_o,
  output logic [W-1:0] shr_o,
  output logic [W-1:0] asr_o,
  output logic [W-1:0] rol_o,
  output logic [W-1:0] ror_o
);
  localparam int MSB = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign shl_o[i] = 1'b0;
      assign rol_o[i] = a_i[MSB];
    end else begin : g_up
      assign shl_o[i] = a_i[i-1];
      assign rol_o[i] = a_i[i-1];
    end
    if (i == MSB) begin : g_hi
      assign shr_o[i] = 1'b0;
      assign asr_o[i] = a_i[MSB];
      assign ror_o[i] = a_i[0];
    end else begin : g_dn
      assign shr_o[i] = a_i[i+1];
      assign asr_o[i] = a_i[i+1];
      assign ror_o[i] = a_i[i+1];
    end
  end

  // R5
  always_comb begin
    if (!$isunknown(a_i))
      rotate_bits_kept_chk: assert ($countones(rol_o) == $countones(a_i)
                                    && $countones(ror_o) == $countones(a_i));
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] not_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign xor_o = a_i ^ b_i;
  assign not_o = ~a_i;

  // R6
  always_comb begin
    if (!$isunknown({a_i, b_i}))
      logic_relation_chk: assert ((and_o ^ xor_o) == or_o && (not_o & a_i) == '0);
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmp_i,
  input  logic [W-1:0]              diff_i,
  input  logic                      cout_i,
  output acc_alu_pkg::alu_flags_t   flags_o
);
  import acc_alu_pkg::*;

  alu_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (cmp_i) begin
      flags_q.z <= (diff_i == '0);
      flags_q.c <= cout_i;
      flags_q.n <= diff_i[W-1];
    end
  end

  assign flags_o = flags_q;

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_i |=> $stable(flags_q));

  // R8
  zero_from_diff_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_i |=> (flags_q.z == ($past(diff_i) == '0)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic         cmp_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         neg_o
);
  import acc_alu_pkg::*;

  logic [W-1:0] sum, r_shl, r_shr, r_asr, r_rol, r_ror;
  logic [W-1:0] r_and, r_or, r_xor, r_not;
  logic         cout, do_sub;
  alu_flags_t   flags;

  assign do_sub = cmp_i || (op_i == OP_SUB);

  acc_alu_adder #(.W(W)) u_adder (
    .a_i(acc_i), .b_i(bus_i), .sub_i(do_sub), .sum_o(sum), .cout_o(cout)
  );

  acc_alu_shifter #(.W(W)) u_shift (
    .a_i(acc_i), .shl_o(r_shl), .shr_o(r_shr), .asr_o(r_asr),
    .rol_o(r_rol), .ror_o(r_ror)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a_i(acc_i), .b_i(bus_i), .and_o(r_and), .or_o(r_or),
    .xor_o(r_xor), .not_o(r_not)
  );

  acc_alu_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .cmp_i(cmp_i), .diff_i(sum), .cout_i(cout),
    .flags_o(flags)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: result_o = sum;
      OP_SHL:         result_o = r_shl;
      OP_SHR:         result_o = r_shr;
      OP_ASR:         result_o = r_asr;
      OP_ROL:         result_o = r_rol;
      OP_ROR:         result_o = r_ror;
      OP_AND:         result_o = r_and;
      OP_OR:          result_o = r_or;
      OP_NOT:         result_o = r_not;
      OP_XOR:         result_o = r_xor;
      default:        result_o = '0;
    endcase
  end

  assign zero_o  = flags.z;
  assign carry_o = flags.c;
  assign neg_o   = flags.n;

  // R8
  carry_no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_i |=> (carry_o == ($past(acc_i) >= $past(bus_i))));

  // R8
  neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_i |=> (neg_o == W'($past(acc_i) - $past(bus_i)) >> (W-1)));

  // R7
  always_comb begin
    if (!$isunknown(op_i) && op_i > OP_XOR)
      unused_op_zero_chk: assert (result_o == '0);
  end
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = '0;
  logic       cmp = 1'b0;
  logic [7:0] acc = '0, bus = '0;
  logic [7:0] result;
  logic       zf, cf, nf;

  int checks = 0;
  int errors = 0;
  logic ez = 1'b0, ec = 1'b0, en = 1'b0;

  always #2 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .op_i(op), .cmp_i(cmp), .acc_i(acc), .bus_i(bus),
    .result_o(result), .zero_o(zf), .carry_o(cf), .neg_o(nf)
  );

  function automatic logic [7:0] model(input logic [3:0] o, input logic [7:0] a,
                                       input logic [7:0] b, input logic c);
    case (o)
      4'd0:    return c ? 8'(a - b) : 8'(a + b);  // R1 R11
      4'd1:    return 8'(a - b);                  // R2
      4'd2:    return {a[6:0], 1'b0};             // R3
      4'd3:    return {1'b0, a[7:1]};             // R4
      4'd4:    return {a[7], a[7:1]};             // R4
      4'd5:    return {a[6:0], a[7]};             // R5
      4'd6:    return {a[0], a[7:1]};             // R5
      4'd7:    return a & b;                      // R6
      4'd8:    return a | b;
      4'd9:    return ~a;
      4'd10:   return a ^ b;
      default: return 8'h00;                      // R7
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o, input logic c);
    if (c && o == 4'd0) return "R11";
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8, 4'd9, 4'd10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_flags(input string req);
    checks++;
    if ({zf, cf, nf} !== {ez, ec, en}) begin
      errors++;
      $display("FAIL %s flags zcn actual %b%b%b expected %b%b%b", req, zf, cf, nf, ez, ec, en);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic c, input logic r);
    logic [7:0] exp_r;
    string fr;
    @(negedge clk);
    op = o; acc = a; bus = b; cmp = c; rst = r;
    #1;
    exp_r = model(o, a, b, c);
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s op %0d acc %h bus %h actual %h expected %h",
               req_of(o, c), o, a, b, result, exp_r);
    end
    @(posedge clk);
    if (r) begin
      ez = 0; ec = 0; en = 0; fr = "R10";
    end else if (c) begin
      ez = (8'(a - b) == 8'h00); ec = (a >= b); en = 8'(a - b) >> 7; fr = "R8";
    end else begin
      fr = "R9";
    end
    #1;
    check_flags(fr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (2) @(posedge clk);
    #1;
    check_flags("R10");                           // reset state
    step(4'd0, 8'h00, 8'h00, 1'b1, 1'b0);         // R8 equal: z=1 c=1 n=0
    step(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0);         // R1 wrap, R9 flags held
    step(4'd1, 8'h00, 8'h01, 1'b1, 1'b0);         // R8 borrow: c=0 n=1
    step(4'd1, 8'h80, 8'h7F, 1'b1, 1'b0);         // R8 c=1 n=0 z=0
    step(4'd0, 8'h80, 8'h80, 1'b0, 1'b0);         // R9 add with carry out
    step(4'd4, 8'h81, 8'h00, 1'b0, 1'b0);         // R4 sign copy
    step(4'd3, 8'h81, 8'h00, 1'b0, 1'b0);         // R4 zero fill
    step(4'd2, 8'hFF, 8'h00, 1'b0, 1'b0);         // R3
    step(4'd5, 8'h80, 8'h00, 1'b0, 1'b0);         // R5
    step(4'd6, 8'h01, 8'h00, 1'b0, 1'b0);         // R5
    step(4'd9, 8'h5A, 8'hFF, 1'b0, 1'b0);         // R6 operand ignored
    step(4'd9, 8'h5A, 8'h00, 1'b0, 1'b0);         // R6
    step(4'd15, 8'hFF, 8'hFF, 1'b0, 1'b0);        // R7
    step(4'd0, 8'h10, 8'h03, 1'b1, 1'b0);         // R11 adder subtracts
    step(4'd0, 8'h00, 8'h00, 1'b1, 1'b1);         // R10 reset beats compare
    for (int i = 0; i < 3000; i++) begin
      step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
           1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 60) == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule